// File: doc/BRIEF.md
# Secondary Interrupt Aggregator

This block gathers 32 level-sensitive interrupt sources and condenses them into a single summary request for an upstream (primary) interrupt controller. A software-owned enable mask selects which sources contribute to the summary. The summary is raised whenever at least one source is both active and enabled. A second enable vector, limited to sources 21 to 30, forwards those raw source levels one-for-one to matching inputs of the primary controller. A source routed this way can then be handled there on its own line.

Software reaches the block through a single-cycle select/write/address/data register port that decodes a 4 KB window. The word offset is taken from byte-address bits [11:2], and read data is valid combinationally in the cycle of the access. The enable mask and the forward-enable vector each have separate set and clear offsets, so no read-modify-write is needed. Two further offsets set or clear the enable bit of source 0, which serves as the software interrupt. Both the summary and the forwarded lines leave the block through flops, so they follow any input or register change one clock later.

Top module: `sirq_aggregator`

## Requirements
- R1: After synchronous reset the enable mask and forward-enable vector are zero, irq_o and fwd_o are low whatever src_i is, and reads of offsets 2 and 8 return zero.
- R2: irq_o equals, one clock later, the OR-reduction of src_i AND the enable mask as it stood at that clock.
- R3: A read of word offset 0 (byte 0x000) returns src_i AND enable mask, and a read of offset 1 (byte 0x004) returns src_i unchanged.
- R4: A write to offset 2 (byte 0x008) ORs the write data into the enable mask, and a read of offset 2 returns the mask.
- R5: A write to offset 3 (byte 0x00C) clears every enable bit that is 1 in the write data and leaves the others.
- R6: A read of offset 4 (byte 0x010) returns only bit 0 of src_i, with bits 31:1 zero. A write there with non-zero data sets enable bit 0, and a write of zero changes nothing.
- R7: A write of non-zero data to offset 5 (byte 0x014) clears enable bit 0 only, and a write of zero changes nothing.
- R8: A write to offset 8 (byte 0x020) ORs in only data bits 30:21 (mask 0x7FE00000) into the forward-enable vector. A read of offset 8 returns that vector.
- R9: A write to offset 9 (byte 0x024) clears every forward-enable bit that is 1 in the write data.
- R10: fwd_o[n] equals, one clock later, src_i[n] AND forward-enable bit n. Bits outside 30:21 are always zero, and a disabled line is driven low.
- R11: Reads of any offset other than 0, 1, 2, 4 and 8 return zero, and writes to any offset other than 2, 3, 4, 5, 8 and 9 change no state.
- R12: A cycle with sel_i low changes no state, whatever wr_i, addr_i and wdata_i carry, and rdata_o is zero when no read is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | 1 = write, 0 = read, qualified by sel_i |
| addr_i | input | 12 | Byte address within the window; bits 11:2 form the word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| src_i | input | 32 | Level-sensitive interrupt sources, bit n = source n |
| irq_o | output | 1 | Registered summary request to the primary controller |
| fwd_o | output | 32 | Registered per-line forwarded source levels (bits 30:21 live) |

## Verification
The assertions assume that src_i and the register port are sampled only at the rising edge, and that at most one register write lands in any cycle. The interface gives no way to issue two, and the checks on set and clear compare the register contents one cycle after exactly one write. The stimulus drives every input on the falling edge and keeps sel_i to a single access per cycle. It also changes src_i only between accesses, so each check sees one cause per clock. Random write data, including zero words and writes to unused offsets, exercise the set, clear, software-bit and ignore paths inside these limits.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    // Fixed geometry of the register window and source vector.
    localparam int unsigned SRC_W  = 32;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned OFF_W  = ADDR_W - 2;

    // Word offsets; software depends on these values.
    typedef enum logic [OFF_W-1:0] {
        REG_PEND    = 10'd0,
        REG_RAW     = 10'd1,
        REG_ENA_SET = 10'd2,
        REG_ENA_CLR = 10'd3,
        REG_SWI_SET = 10'd4,
        REG_SWI_CLR = 10'd5,
        REG_FWD_SET = 10'd8,
        REG_FWD_CLR = 10'd9
    } reg_sel_e;

    // One decoded register access.
    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [OFF_W-1:0] off;
        logic [SRC_W-1:0] data;
    } bus_req_t;

    // Per-source state held by the register file.
    typedef struct packed {
        logic [SRC_W-1:0] ena;
        logic [SRC_W-1:0] fwd;
    } ctl_state_t;

    // Mask with ones from bit lo up to bit hi inclusive.
    function automatic logic [SRC_W-1:0] window_mask(int unsigned lo, int unsigned hi);
        logic [SRC_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < SRC_W; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Offsets that hold write side effects.
    function automatic logic off_writable(logic [OFF_W-1:0] off);
        return (off == REG_ENA_SET) || (off == REG_ENA_CLR) ||
               (off == REG_SWI_SET) || (off == REG_SWI_CLR) ||
               (off == REG_FWD_SET) || (off == REG_FWD_CLR);
    endfunction

endpackage

// File: rtl/sirq_bus_decode.sv
module sirq_bus_decode
    import sirq_pkg::*;
(
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]  wdata,
    output bus_req_t          req
);

    // Byte lanes below the word boundary carry no meaning here.
    logic unused_lsb;
    assign unused_lsb = ^addr[1:0];

    always_comb begin
        req.rd   = sel & ~wr;
        req.wr   = sel & wr;
        req.off  = addr[ADDR_W-1:2];
        req.data = wdata;
    end

endmodule

// File: rtl/sirq_regfile.sv
module sirq_regfile
    import sirq_pkg::*;
#(
    parameter int unsigned FWD_LO = 21,
    parameter int unsigned FWD_HI = 30
)(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [SRC_W-1:0] src,
    output ctl_state_t       ctl,
    output logic [SRC_W-1:0] rdata
);

    localparam logic [SRC_W-1:0] WIN = window_mask(FWD_LO, FWD_HI);

    ctl_state_t ctl_q;
    ctl_state_t ctl_d;

    // Next-state for the set/clear registers.
    always_comb begin
        ctl_d = ctl_q;
        if (req.wr) begin
            case (req.off)
                REG_ENA_SET: ctl_d.ena = ctl_q.ena | req.data;
                REG_ENA_CLR: ctl_d.ena = ctl_q.ena & ~req.data;
                REG_SWI_SET: if (|req.data) ctl_d.ena[0] = 1'b1;
                REG_SWI_CLR: if (|req.data) ctl_d.ena[0] = 1'b0;
                REG_FWD_SET: ctl_d.fwd = ctl_q.fwd | (req.data & WIN);
                REG_FWD_CLR: ctl_d.fwd = ctl_q.fwd & ~req.data;
                default:     ctl_d = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    // Combinational read path.
    always_comb begin
        rdata = '0;
        if (req.rd) begin
            case (req.off)
                REG_PEND:    rdata = src & ctl_q.ena;
                REG_RAW:     rdata = src;
                REG_ENA_SET: rdata = ctl_q.ena;
                REG_SWI_SET: rdata = {{(SRC_W-1){1'b0}}, src[0]};
                REG_FWD_SET: rdata = ctl_q.fwd;
                default:     rdata = '0;
            endcase
        end
    end

    assign ctl = ctl_q;

    AST_ENA_SET: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.off == REG_ENA_SET) |=> ((ctl_q.ena & $past(req.data)) == $past(req.data))); // R4
    AST_ENA_CLR: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.off == REG_ENA_CLR) |=> ((ctl_q.ena & $past(req.data)) == '0)); // R5
    AST_SWI_SET: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.off == REG_SWI_SET && req.data != '0) |=> ctl_q.ena[0]); // R6
    AST_SWI_CLR: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.off == REG_SWI_CLR && req.data != '0) |=> !ctl_q.ena[0]); // R7
    AST_FWD_SET: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.off == REG_FWD_SET) |=>
        ((ctl_q.fwd & $past(req.data & WIN)) == $past(req.data & WIN))); // R8
    AST_FWD_CLR: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.off == REG_FWD_CLR) |=> ((ctl_q.fwd & $past(req.data)) == '0)); // R9
    AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req.wr && !off_writable(req.off)) |=> ($stable(ctl_q.ena) && $stable(ctl_q.fwd))); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req.wr |=> ($stable(ctl_q.ena) && $stable(ctl_q.fwd))); // R12
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !req.rd |-> (rdata == '0)); // R12

endmodule

// File: rtl/sirq_summary.sv
module sirq_summary
    import sirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src,
    input  logic [SRC_W-1:0] ena,
    output logic             irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(src & ena);
    end

    assign irq = irq_q;

    AST_SUMMARY_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_q == $past(|(src & ena)))); // R2

endmodule

// File: rtl/sirq_route.sv
module sirq_route
    import sirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src,
    input  logic [SRC_W-1:0] fwd_en,
    output logic [SRC_W-1:0] fwd
);

    // One flop per line; a line whose enable is clear is forced low.
    for (genvar n = 0; n < SRC_W; n++) begin : g_line
        logic line_q;

        always_ff @(posedge clk) begin
            if (rst) line_q <= 1'b0;
            else     line_q <= fwd_en[n] & src[n];
        end

        assign fwd[n] = line_q;

        AST_FWD_TRACK: assert property (@(posedge clk) disable iff (rst)
            (fwd_en[n] && src[n]) |=> line_q); // R10
        AST_FWD_OFF: assert property (@(posedge clk) disable iff (rst)
            !(fwd_en[n] && src[n]) |=> !line_q); // R10
    end

endmodule

// File: rtl/sirq_aggregator.sv
module sirq_aggregator
    import sirq_pkg::*;
#(
    parameter int unsigned FWD_LO = 21,
    parameter int unsigned FWD_HI = 30
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SRC_W-1:0]  wdata_i,
    output logic [SRC_W-1:0]  rdata_o,
    input  logic [SRC_W-1:0]  src_i,
    output logic              irq_o,
    output logic [SRC_W-1:0]  fwd_o
);

    localparam logic [SRC_W-1:0] WIN = window_mask(FWD_LO, FWD_HI);

    bus_req_t   req;
    ctl_state_t ctl;

    sirq_bus_decode u_decode (
        .sel   (sel_i),
        .wr    (wr_i),
        .addr  (addr_i),
        .wdata (wdata_i),
        .req   (req)
    );

    sirq_regfile #(
        .FWD_LO (FWD_LO),
        .FWD_HI (FWD_HI)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .src   (src_i),
        .ctl   (ctl),
        .rdata (rdata_o)
    );

    sirq_summary u_summary (
        .clk (clk),
        .rst (rst),
        .src (src_i),
        .ena (ctl.ena),
        .irq (irq_o)
    );

    sirq_route u_route (
        .clk    (clk),
        .rst    (rst),
        .src    (src_i),
        .fwd_en (ctl.fwd),
        .fwd    (fwd_o)
    );

    AST_FWD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fwd_o & ~WIN) == '0)); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq_o && fwd_o == '0)); // R1

endmodule

// File: tb/sirq_aggregator_test.sv
module sirq_aggregator_test;

    localparam logic [31:0] WIN = 32'h7FE0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [31:0] src_i = '0;
    logic        irq_o;
    logic [31:0] fwd_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_ena = '0;
    logic [31:0] m_fwd = '0;

    always #10 clk = ~clk;

    sirq_aggregator uut (
        .clk (clk), .rst (rst), .sel_i (sel_i), .wr_i (wr_i),
        .addr_i (addr_i), .wdata_i (wdata_i), .rdata_o (rdata_o),
        .src_i (src_i), .irq_o (irq_o), .fwd_o (fwd_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [31:0] exp_read(int off);
        case (off)
            0:       return src_i & m_ena;
            1:       return src_i;
            2:       return m_ena;
            4:       return {31'b0, src_i[0]};
            8:       return m_fwd;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(int off);
        case (off)
            0, 1:    return "R3";
            2:       return "R4";
            4:       return "R6";
            8:       return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic model_write(int off, logic [31:0] d);
        case (off)
            2: m_ena = m_ena | d;
            3: m_ena = m_ena & ~d;
            4: if (d != 0) m_ena[0] = 1'b1;
            5: if (d != 0) m_ena[0] = 1'b0;
            8: m_fwd = m_fwd | (d & WIN);
            9: m_fwd = m_fwd & ~d;
            default: ;
        endcase
    endtask

    task automatic bus_write(int off, logic [31:0] d);
        @(negedge clk);
        sel_i = 1'b1; wr_i = 1'b1; addr_i = 12'(off << 2); wdata_i = d;
        @(posedge clk);
        @(negedge clk);
        sel_i = 1'b0; wr_i = 1'b0;
        model_write(off, d);
    endtask

    task automatic bus_read(int off, string req);
        @(negedge clk);
        sel_i = 1'b1; wr_i = 1'b0; addr_i = 12'(off << 2);
        #2;
        chk(req, rdata_o, exp_read(off));
        @(negedge clk);
        sel_i = 1'b0;
    endtask

    // Outputs settle one edge after the last change.
    task automatic check_outputs(string tag);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R2"}, {31'b0, irq_o}, {31'b0, |(src_i & m_ena)});
        chk({tag, " R10"}, fwd_o, src_i & m_fwd);
    endtask

    task automatic set_src(logic [31:0] v);
        @(negedge clk);
        src_i = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int offs[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 1023};
        void'($urandom(32'd4242));

        // R1: reset with all sources active
        src_i = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_outputs("R1");
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 fwd", fwd_o, 32'h0);
        bus_read(2, "R1");
        bus_read(8, "R1");
        bus_read(1, "R3");

        // R4/R5 directed
        bus_write(2, 32'h0000_00F0);
        bus_write(2, 32'h8000_0001);
        bus_read(2, "R4");
        check_outputs("R4");
        bus_write(3, 32'h0000_0030);
        bus_read(2, "R5");
        bus_read(0, "R3");

        // R6/R7: zero writes change nothing, non-zero toggles bit 0
        bus_write(3, 32'hFFFF_FFFF);
        bus_write(4, 32'h0);
        bus_read(2, "R6");
        bus_write(4, 32'h0100_0000);
        bus_read(2, "R6");
        set_src(32'h0000_0001);
        check_outputs("R6");
        bus_read(4, "R6");
        set_src(32'hFFFF_FFFE);
        bus_read(4, "R6");
        bus_write(5, 32'h0);
        bus_read(2, "R7");
        bus_write(2, 32'h0000_0006);
        bus_write(5, 32'h0000_0008);
        bus_read(2, "R7");

        // R8/R9: window restriction and clear
        bus_write(8, 32'hFFFF_FFFF);
        bus_read(8, "R8");
        set_src(32'hFFFF_FFFF);
        check_outputs("R8");
        chk("R10 window", fwd_o & ~WIN, 32'h0);
        bus_write(9, 32'h1020_0000);
        bus_read(8, "R9");
        check_outputs("R9");
        set_src(32'h5555_5555);
        check_outputs("R10");

        // R11: unused offsets
        bus_write(6, 32'hFFFF_FFFF);
        bus_write(7, 32'hFFFF_FFFF);
        bus_write(0, 32'hFFFF_FFFF);
        bus_write(1023, 32'hFFFF_FFFF);
        bus_read(2, "R11");
        bus_read(8, "R11");
        bus_read(3, "R11");
        bus_read(9, "R11");
        bus_read(1023, "R11");

        // R12: deselected writes
        @(negedge clk);
        sel_i = 1'b0; wr_i = 1'b1; addr_i = 12'h008; wdata_i = 32'hFFFF_FFFF;
        #2;
        chk("R12 rdata", rdata_o, 32'h0);
        @(negedge clk);
        addr_i = 12'h020;
        @(negedge clk);
        wr_i = 1'b0;
        bus_read(2, "R12");
        bus_read(8, "R12");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: begin
                    set_src($urandom);
                    check_outputs("rand");
                end
                1: begin
                    int off;
                    logic [31:0] d;
                    off = offs[$urandom_range(0, 11)];
                    d = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
                    bus_write(off, d);
                    check_outputs("rand");
                end
                2: begin
                    int off;
                    off = offs[$urandom_range(0, 11)];
                    bus_read(off, read_tag(off));
                end
                default: begin
                    @(negedge clk);
                    sel_i = 1'b0; wr_i = 1'b1; wdata_i = $urandom;
                    addr_i = 12'(offs[$urandom_range(0, 11)] << 2);
                    @(negedge clk);
                    wr_i = 1'b0;
                    bus_read(2, "R12");
                    bus_read(8, "R12");
                end
            endcase
        end

        finish_run();
    end

endmodule